// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an EDO DRAM array alive by issuing refresh cycles in which the column strobes fall before the row strobe. Because the device keeps its own internal row counter in this mode, the block generates no address. It shares the memory pins with an access controller. Whenever a refresh is owed, the block raises a bus request, waits for a grant, drives the strobe pattern, and then returns the bus.

Out of reset the block first waits out a power-up pause. It then runs a fixed burst of initialisation refresh cycles, and only after that burst raises its ready output. From then on, a periodic timer produces one refresh request per interval. If the grant is late, a small backlog counter holds the requests that are owed. A request that arrives while the backlog is already full sets a sticky error flag.

All durations are counted in clock cycles and set by parameters. The defaults suit a 125 MHz clock: a 15.6 µs refresh interval, a 200 µs pause, eight initialisation cycles, 8 ns of column setup, 8 ns of column hold, 56 ns of row-low time and 32 ns of precharge.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, bus_req is 0, ras_n is 1, every cas_n bit is 1, we_n is 1, ready is 0 and ovf_err is 0.
- R2: After reset is released, bus_req stays low for at least PWRUP_CYCLES clocks and rises no later than PWRUP_CYCLES+2 clocks.
- R3: After the pause, exactly INIT_CYCLES complete refresh cycles run. ready rises on the clock edge that ends the last of them (the same edge on which bus_req falls) and then stays high until reset. No further cycle starts until the timer asks for one.
- R4: Strobes are driven low only after bus_gnt has been sampled high while bus_req is high. The column strobes fall on the first clock edge that samples the grant, so the row strobe falls T_SETUP+d+1 clocks after bus_req rises, where d is the number of clocks the grant lags the request.
- R5: In each refresh cycle, all cas_n bits are low for exactly T_SETUP clocks before ras_n falls, while ras_n is still high. They stay low for exactly T_HOLD clocks after ras_n falls.
- R6: ras_n stays low for exactly T_RAS clocks. It is then high, with all cas_n bits high, for exactly T_PRE clocks before bus_req falls. bus_req stays high throughout the cycle.
- R7: we_n is 1 at all times, and all cas_n bits always carry the same value.
- R8: With an immediate grant in steady operation, consecutive ras_n falling edges are exactly REFI_CYCLES clocks apart.
- R9: Timer requests that arrive while the grant is withheld are held, up to BACKLOG_DEPTH of them. Once the grant returns they are served as back-to-back cycles, and ovf_err stays 0.
- R10: A timer request that arrives while BACKLOG_DEPTH requests are already held sets ovf_err. ovf_err stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | output | 1 | Asks the access controller for the memory pins; held until the refresh cycle ends |
| bus_gnt | input | 1 | Grant from the access controller; must stay high while bus_req is high |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_W | Byte column strobes, active low, always driven together |
| we_n | output | 1 | Write enable, held inactive high |
| ready | output | 1 | Power-up pause and initialisation burst are complete |
| ovf_err | output | 1 | Sticky flag: a refresh request was lost to a full backlog |

## Verification
The bench measures the edges of every refresh cycle from the strobe pins. Its checks catch a design that drops the row strobe before the column strobes, or that shortens the row-low or precharge windows by one clock. The grant lag is varied, so a design that starts strobing before the grant, or that counts the setup time from the request instead of the grant, shows a wrong request-to-row-strobe distance. The initialisation count is checked against the edge on which ready rises, which catches an off-by-one in the burst and a ready that comes too early. The backlog tests withhold the grant first for two intervals and then for five. A backlog that is too shallow, or an error flag that fires early or clears itself, is seen as a wrong ovf_err value.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    CBR_IDLE,
    CBR_REQ,
    CBR_SETUP,
    CBR_HOLD,
    CBR_RASLO,
    CBR_PRECH
  } cbr_state_e;

  typedef enum logic [1:0] {
    PH_WAIT,
    PH_INIT,
    PH_RUN
  } phase_e;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int PERIOD = 1950
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;

  // one-cycle pulse every PERIOD clocks while enabled
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(PERIOD - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic add,
  input  logic take,
  output logic pending,
  output logic overflow
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      overflow <= 1'b0;
    end else if (add && !take) begin
      if (cnt == CW'(DEPTH)) overflow <= 1'b1;
      else                   cnt      <= cnt + 1'b1;
    end else if (take && !add && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign pending = (cnt != '0);
endmodule

// File: rtl/powerup_gate.sv
module powerup_gate
  import dram_refresh_pkg::*;
#(
  parameter int PWRUP_CYCLES = 25000,
  parameter int INIT_CYCLES  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  output logic init_need,
  output logic ready
);
  localparam int PW = (PWRUP_CYCLES > 1) ? $clog2(PWRUP_CYCLES) : 1;
  localparam int IW = $clog2(INIT_CYCLES + 1);

  phase_e        ph;
  logic [PW-1:0] pw_cnt;
  logic [IW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_WAIT;
      pw_cnt <= '0;
      left   <= IW'(INIT_CYCLES);
    end else begin
      case (ph)
        PH_WAIT: begin
          if (pw_cnt == PW'(PWRUP_CYCLES - 1)) ph <= PH_INIT;
          else                                 pw_cnt <= pw_cnt + 1'b1;
        end
        PH_INIT: begin
          if (start && left != '0) left <= left - 1'b1;
          // ready only once the last burst cycle has fully finished
          if (done && left == '0)  ph   <= PH_RUN;
        end
        default: ph <= PH_RUN;
      endcase
    end
  end

  assign init_need = (ph == PH_INIT) && (left != '0);
  assign ready     = (ph == PH_RUN);
endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
  import dram_refresh_pkg::*;
#(
  parameter int T_SETUP = 1,
  parameter int T_HOLD  = 1,
  parameter int T_RAS   = 7,
  parameter int T_PRE   = 4,
  parameter int CAS_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             need,
  input  logic             bus_gnt,
  output logic             start,
  output logic             done,
  output logic             bus_req,
  output logic             ras_n,
  output logic [CAS_W-1:0] cas_n
);
  localparam int T_LOW = T_RAS - T_HOLD;
  localparam int M1    = (T_SETUP > T_HOLD) ? T_SETUP : T_HOLD;
  localparam int M2    = (T_LOW > T_PRE) ? T_LOW : T_PRE;
  localparam int TMAX  = (M1 > M2) ? M1 : M2;
  localparam int CW    = $clog2(TMAX + 1);

  cbr_state_e    st, nxt;
  logic [CW-1:0] cnt, ld_val;
  logic          ld;

  always_comb begin
    nxt    = st;
    ld     = 1'b0;
    ld_val = '0;
    case (st)
      CBR_IDLE:  if (need) nxt = CBR_REQ;
      CBR_REQ:   if (bus_gnt) begin
                   nxt = CBR_SETUP; ld = 1'b1; ld_val = CW'(T_SETUP - 1);
                 end
      CBR_SETUP: if (cnt == '0) begin
                   nxt = CBR_HOLD;  ld = 1'b1; ld_val = CW'(T_HOLD - 1);
                 end
      CBR_HOLD:  if (cnt == '0) begin
                   nxt = CBR_RASLO; ld = 1'b1; ld_val = CW'(T_LOW - 1);
                 end
      CBR_RASLO: if (cnt == '0) begin
                   nxt = CBR_PRECH; ld = 1'b1; ld_val = CW'(T_PRE - 1);
                 end
      CBR_PRECH: if (cnt == '0) nxt = CBR_IDLE;
      default:   nxt = CBR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= CBR_IDLE;
      cnt     <= '0;
      bus_req <= 1'b0;
      ras_n   <= 1'b1;
      cas_n   <= '1;
    end else begin
      st <= nxt;
      if (ld)              cnt <= ld_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
      // pins follow the state being entered, so they are registered
      bus_req <= (nxt != CBR_IDLE);
      ras_n   <= !(nxt == CBR_HOLD || nxt == CBR_RASLO);
      cas_n   <= (nxt == CBR_SETUP || nxt == CBR_HOLD) ? '0 : '1;
    end
  end

  assign start = (st == CBR_REQ) && bus_gnt;
  assign done  = (st == CBR_PRECH) && (cnt == '0);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int REFI_CYCLES   = 1950,
  parameter int PWRUP_CYCLES  = 25000,
  parameter int INIT_CYCLES   = 8,
  parameter int BACKLOG_DEPTH = 4,
  parameter int T_SETUP       = 1,
  parameter int T_HOLD        = 1,
  parameter int T_RAS         = 7,
  parameter int T_PRE         = 4,
  parameter int CAS_W         = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             ras_n,
  output logic [CAS_W-1:0] cas_n,
  output logic             we_n,
  output logic             ready,
  output logic             ovf_err
);
  logic tick, pending, init_need, need, start, done;

  refresh_interval_timer #(.PERIOD(REFI_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .en(ready), .tick(tick)
  );

  refresh_backlog #(.DEPTH(BACKLOG_DEPTH)) u_backlog (
    .clk(clk), .rst(rst), .add(tick), .take(start && ready),
    .pending(pending), .overflow(ovf_err)
  );

  powerup_gate #(.PWRUP_CYCLES(PWRUP_CYCLES), .INIT_CYCLES(INIT_CYCLES)) u_pwr (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .init_need(init_need), .ready(ready)
  );

  assign need = init_need || (ready && pending);

  cbr_sequencer #(
    .T_SETUP(T_SETUP), .T_HOLD(T_HOLD), .T_RAS(T_RAS), .T_PRE(T_PRE), .CAS_W(CAS_W)
  ) u_seq (
    .clk(clk), .rst(rst), .need(need), .bus_gnt(bus_gnt),
    .start(start), .done(done), .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n)
  );

  // refresh never writes
  always_ff @(posedge clk) we_n <= 1'b1;
endmodule

// File: rtl/refresh_seq_chk.sv
module refresh_seq_chk #(
  parameter int T_RAS = 7,
  parameter int CAS_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             ras_n,
  input logic [CAS_W-1:0] cas_n,
  input logic             ready,
  input logic             ovf_err
);
  localparam int LW = $clog2(T_RAS + 2) + 1;

  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst || ras_n)      lo_cnt <= '0;
    else if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
  end

  AST_STROBE_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    (cas_n != {CAS_W{1'b1}}) |-> $past(bus_gnt)); // R4
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (cas_n == {CAS_W{1'b0}})); // R5
  AST_CAS_FALLS_RAS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cas_n == {CAS_W{1'b0}} && $past(cas_n) == {CAS_W{1'b1}}) |-> ras_n); // R5
  AST_RAS_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (lo_cnt >= LW'(T_RAS))); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    !ras_n |=> bus_req); // R6
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err); // R10
endmodule

bind dram_refresh_seq refresh_seq_chk #(.T_RAS(T_RAS), .CAS_W(CAS_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt), .ras_n(ras_n),
  .cas_n(cas_n), .ready(ready), .ovf_err(ovf_err)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int REFI  = 60;
  localparam int PWRUP = 100;
  localparam int INIT  = 8;
  localparam int DEPTH = 3;
  localparam int TSU   = 1;
  localparam int THD   = 1;
  localparam int TRAS  = 7;
  localparam int TPRE  = 4;

  // grant lag, expected clocks from bus_req rise to row strobe fall (R4)
  localparam int NROW = 4;
  localparam int VEC[NROW][2] = '{'{0, 2}, '{2, 4}, '{7, 9}, '{20, 22}};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_gnt = 1'b0;
  logic       bus_req, ras_n, we_n, ready, ovf_err;
  logic [1:0] cas_n;

  int checks = 0, errors = 0;
  int gnt_delay = 0, wait_cnt = 0;
  bit gnt_block = 1'b0;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .REFI_CYCLES(REFI), .PWRUP_CYCLES(PWRUP), .INIT_CYCLES(INIT),
    .BACKLOG_DEPTH(DEPTH), .T_SETUP(TSU), .T_HOLD(THD), .T_RAS(TRAS),
    .T_PRE(TPRE), .CAS_W(2)
  ) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ready(ready), .ovf_err(ovf_err)
  );

  // access controller model: grants gnt_delay clocks after the request
  initial forever begin
    @(negedge clk);
    if (!bus_req) begin
      bus_gnt  = 1'b0;
      wait_cnt = 0;
    end else if (!bus_gnt && !gnt_block) begin
      if (wait_cnt >= gnt_delay) bus_gnt = 1'b1;
      else                       wait_cnt++;
    end
  end

  // pin monitor
  int  lead = 0, hold = 0, rlo = 0, pre = 0, r2f = 0, intv = 0;
  int  last_lead = 0, last_hold = 0, last_ras = 0, last_pre = 0, last_r2f = 0, last_intv = 0;
  int  done_cnt = 0, viol_gnt = 0, viol_we = 0, viol_split = 0;
  bit  after_rise = 1'b0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_req = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      intv++;
      if ((!ras_n || cas_n != 2'b11) && !bus_gnt) viol_gnt++;
      if (!we_n) viol_we++;
      if (cas_n[0] != cas_n[1]) viol_split++;
      if (!bus_req) r2f = 0;
      else if (ras_n) r2f++;
      if (!cas_n[0] && ras_n) lead++;
      if (!cas_n[0] && !ras_n) hold++;
      if (!ras_n) rlo++;
      if (p_ras && !ras_n) begin
        last_lead = lead; lead = 0;
        last_r2f  = r2f;
        last_intv = intv; intv = 0;
      end
      if (!p_cas && cas_n[0]) begin last_hold = hold; hold = 0; end
      if (!p_ras && ras_n) begin last_ras = rlo; rlo = 0; after_rise = 1'b1; end
      if (after_rise && ras_n && cas_n == 2'b11 && bus_req) pre++;
      if (p_req && !bus_req) begin
        last_pre = pre; pre = 0; after_rise = 1'b0; done_cnt++;
      end
    end
    p_ras = ras_n; p_cas = cas_n[0]; p_req = bus_req;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    int target = done_cnt + 1;
    int budget = 0;
    while (done_cnt < target && budget < 1000) begin
      @(posedge clk);
      budget++;
    end
    check(done_cnt >= target, "refresh cycle completion timeout", done_cnt, target);
    @(negedge clk);
  endtask

  task automatic check_reset_state(input string when);
    check(bus_req == 1'b0, {"R1 bus_req ", when}, int'(bus_req), 0);
    check(ras_n == 1'b1,   {"R1 ras_n ", when},   int'(ras_n), 1);
    check(cas_n == 2'b11,  {"R1 cas_n ", when},   int'(cas_n), 3);
    check(we_n == 1'b1,    {"R1 we_n ", when},    int'(we_n), 1);
    check(ready == 1'b0,   {"R1 ready ", when},   int'(ready), 0);
    check(ovf_err == 1'b0, {"R1 ovf_err ", when}, int'(ovf_err), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int base;
    repeat (4) @(negedge clk);
    check_reset_state("in reset");
    rst = 1'b0;

    // R2: power-up pause
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bus_req && n < PWRUP + 20);
    check(n >= PWRUP && n <= PWRUP + 2, "R2 clocks before first request", n, PWRUP + 1);

    // R3: initialisation burst and ready
    for (int i = 1; i <= INIT; i++) begin
      wait_done();
      check(ready == (i == INIT), "R3 ready after init cycle", int'(ready), int'(i == INIT));
    end
    repeat (10) @(negedge clk);
    check(bus_req == 1'b0, "R3 no extra cycle after burst", int'(bus_req), 0);

    // R8: periodic spacing in steady state
    wait_done();
    wait_done();
    check(last_intv == REFI, "R8 row strobe spacing", last_intv, REFI);

    // table of grant lags: R4, R5, R6
    for (int r = 0; r < NROW; r++) begin
      gnt_delay = VEC[r][0];
      wait_done();
      check(last_r2f == VEC[r][1], "R4 request to row strobe clocks", last_r2f, VEC[r][1]);
      check(last_lead == TSU, "R5 column setup clocks", last_lead, TSU);
      check(last_hold == THD, "R5 column hold clocks", last_hold, THD);
      check(last_ras == TRAS, "R6 row low clocks", last_ras, TRAS);
      check(last_pre == TPRE, "R6 precharge clocks", last_pre, TPRE);
    end
    check(viol_gnt == 0, "R4 strobes without grant", viol_gnt, 0);
    check(viol_we == 0, "R7 we_n low", viol_we, 0);
    check(viol_split == 0, "R7 byte strobes differ", viol_split, 0);

    // R9: backlog within depth
    gnt_delay = 0;
    gnt_block = 1'b1;
    repeat (2 * REFI + 12) @(negedge clk);
    check(ovf_err == 1'b0, "R9 no error while backlog fits", int'(ovf_err), 0);
    check(bus_req == 1'b1, "R9 request held while grant withheld", int'(bus_req), 1);
    base = done_cnt;
    gnt_block = 1'b0;
    repeat (40) @(negedge clk);
    check(done_cnt - base >= 2, "R9 backlog served back to back", done_cnt - base, 2);
    check(ovf_err == 1'b0, "R9 no error after drain", int'(ovf_err), 0);

    // R10: overflow
    wait_done();
    gnt_block = 1'b1;
    repeat (5 * REFI) @(negedge clk);
    check(ovf_err == 1'b1, "R10 overflow flagged", int'(ovf_err), 1);
    gnt_block = 1'b0;
    repeat (100) @(negedge clk);
    check(ovf_err == 1'b1, "R10 flag sticky after drain", int'(ovf_err), 1);
    check(viol_gnt == 0, "R4 strobes without grant after backlog", viol_gnt, 0);

    // R1: reset in operation
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("after mid-run reset");
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("first cycle after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule